// File: doc/BRIEF.md
# SDRAM Open-Row Tracker with Address Mapping

This block turns a flat system byte address into the chip select, bank, row and column of a mobile SDRAM. It keeps an open-row record for every bank of each of two chip selects. A command scheduler asks it about each pending request and gets back a same-cycle verdict: page hit, page miss or idle bank. The scheduler then tells the block which activate, precharge and precharge-all commands it has issued, so the records follow the state of the memory.

Each chip select has its own configuration: a density code that sets the bank count, a row width of 11 to 14 bits and a column width of 8 to 11 bits. Two settings are shared by both chip selects. One is the data path width, which sets how many low byte-offset bits are dropped. The other selects the field order. In the linear order the bank bits sit above the row. In the interleaved order the bank bits sit between the column and the row, so neighbouring pages fall into different banks.

Each record is a two-state machine. It has the states REC_CLOSED and REC_OPEN, with the transitions OPEN (activate while closed), REOPEN (activate while open, which loads the new row), CLOSE (precharge or precharge-all while open) and HOLD (no command for that bank).

Top module: `sdram_row_tracker`

## Requirements
- R1: With `cfg_bank_mid`=0, the local address above the byte offset holds the column first, then the row, then the bank. These fields are reported on `cls_col`, `cls_row` and `cls_bank`.
- R2: With `cfg_bank_mid`=1, the order above the byte offset is column first, then bank, then row.
- R3: `cfg_wide`=1 (32-bit path) drops address bits [1:0] before the column. `cfg_wide`=0 (16-bit path) drops bit [0] only.
- R4: A density code of 0 or 1 gives 2 banks and a 1-bit bank field. Codes 2 to 8 give 4 banks and a 2-bit bank field. A chip select's capacity in bytes is 2^(offset + column width + row width + bank bits), where the column width is 8 + `colw` and the row width is 11 + `roww`.
- R5: An address below the capacity of chip select 0 maps to chip select 0. An address from that capacity up to the sum of both capacities maps to chip select 1, with the capacity of chip select 0 subtracted first. Any other address, and any address at or above 2^30, is classified as error (code 3).
- R6: `cls_code` is combinational in the request cycle. It is 0 for an idle bank, 1 for a hit (the bank is open on the same row), 2 for a miss (the bank is open on another row) and 3 for an error. It is 0 whenever `req_valid` is low.
- R7: An activate opens the named record with the given row from the next clock edge on. An activate naming bank 2 or 3 on a 2-bank chip select is ignored.
- R8: A precharge closes the named record from the next edge on. When an activate names the same bank in the same cycle, the activate wins.
- R9: A precharge-all closes every record of the named chip select and leaves the other chip select untouched.
- R10: Reset closes every record.
- R11: A command to one chip select never changes a record of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wide | input | 1 | 1: 32-bit data path, 0: 16-bit |
| cfg_bank_mid | input | 1 | 1: bank field between column and row |
| cfg_dens0 | input | 4 | Density code, chip select 0 |
| cfg_roww0 | input | 2 | Row width minus 11, chip select 0 |
| cfg_colw0 | input | 2 | Column width minus 8, chip select 0 |
| cfg_dens1 | input | 4 | Density code, chip select 1 |
| cfg_roww1 | input | 2 | Row width minus 11, chip select 1 |
| cfg_colw1 | input | 2 | Column width minus 8, chip select 1 |
| req_valid | input | 1 | Request present |
| req_addr | input | 32 | Request byte address |
| cls_code | output | 2 | Classification code |
| cls_cs | output | 1 | Decoded chip select |
| cls_bank | output | 2 | Decoded bank |
| cls_row | output | 14 | Decoded row |
| cls_col | output | 11 | Decoded column |
| act_valid | input | 1 | Activate issued |
| act_cs | input | 1 | Activate chip select |
| act_bank | input | 2 | Activate bank |
| act_row | input | 14 | Activate row |
| pre_valid | input | 1 | Precharge issued |
| pre_cs | input | 1 | Precharge chip select |
| pre_bank | input | 2 | Precharge bank |
| pall_valid | input | 1 | Precharge-all issued |
| pall_cs | input | 1 | Precharge-all chip select |

## Verification
A record stuck in the wrong state shows up the first time a request decodes to that bank. The verdict is combinational, so the error is visible in the same cycle as the probe, one edge after the command that should have changed the record. A wrong decode field, such as a misplaced bank bit or a wrong offset, shows at once on the field outputs, and it also steers hits to the wrong record. For this reason each ordering and width setting is probed with addresses whose fields are all distinct. A wrong chip-select boundary turns an in-range address into an error, or an out-of-range address into a valid one, in the request cycle.

// File: rtl/row_trk_pkg.sv
package row_trk_pkg;
    localparam int ADDR_W  = 32;
    localparam int SPACE_W = 30;
    localparam int ROW_W   = 14;
    localparam int COL_W   = 11;
    localparam int BANK_W  = 2;
    localparam int NUM_CS  = 2;
    localparam int BANKS   = 1 << BANK_W;
    localparam int REC_N   = NUM_CS * BANKS;
    localparam int IDX_W   = $clog2(REC_N);

    typedef enum logic [1:0] {
        CLS_IDLE = 2'd0,
        CLS_HIT  = 2'd1,
        CLS_MISS = 2'd2,
        CLS_ERR  = 2'd3
    } cls_e;

    typedef enum logic {
        REC_CLOSED = 1'b0,
        REC_OPEN   = 1'b1
    } rec_e;

    typedef struct packed {
        logic [3:0] dens;
        logic [1:0] roww;
        logic [1:0] colw;
    } cs_cfg_t;
endpackage

// File: rtl/addr_map.sv
module addr_map
    import row_trk_pkg::*;
(
    input  logic              cfg_wide,
    input  logic              cfg_bank_mid,
    input  cs_cfg_t           cfg0,
    input  cs_cfg_t           cfg1,
    input  logic [ADDR_W-1:0] addr,
    output logic              err_o,
    output logic              cs_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);
    localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

    logic [5:0] off, cw0, rw0, bb0, cap0, cw1, rw1, bb1, cap1;
    logic [5:0] cw, rw, bb, row_sh, bank_sh;
    logic [ADDR_W:0] lim0, lim1, wide_a, loc;

    always_comb begin
        off  = cfg_wide ? 6'd2 : 6'd1;
        bb0  = (cfg0.dens >= 4'd2) ? 6'd2 : 6'd1;
        bb1  = (cfg1.dens >= 4'd2) ? 6'd2 : 6'd1;
        cw0  = 6'd8 + {4'd0, cfg0.colw};
        rw0  = 6'd11 + {4'd0, cfg0.roww};
        cw1  = 6'd8 + {4'd0, cfg1.colw};
        rw1  = 6'd11 + {4'd0, cfg1.roww};
        cap0 = off + cw0 + rw0 + bb0;
        cap1 = off + cw1 + rw1 + bb1;
        lim0 = ONE << cap0;
        lim1 = lim0 + (ONE << cap1);

        wide_a = {1'b0, addr};
        err_o  = (|(addr >> SPACE_W)) || (wide_a >= lim1);
        cs_o   = (wide_a >= lim0);
        loc    = cs_o ? (wide_a - lim0) : wide_a;

        cw = cs_o ? cw1 : cw0;
        rw = cs_o ? rw1 : rw0;
        bb = cs_o ? bb1 : bb0;
        if (cfg_bank_mid) begin
            bank_sh = off + cw;
            row_sh  = off + cw + bb;
        end else begin
            row_sh  = off + cw;
            bank_sh = off + cw + rw;
        end

        col_o  = COL_W'((loc >> off) & ((ONE << cw) - ONE));
        row_o  = ROW_W'((loc >> row_sh) & ((ONE << rw) - ONE));
        bank_o = BANK_W'((loc >> bank_sh) & ((ONE << bb) - ONE));
    end
endmodule

// File: rtl/bank_rec.sv
module bank_rec
    import row_trk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic             clr_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o
);
    rec_e state_q, state_d;
    logic [ROW_W-1:0] row_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            REC_CLOSED: if (set_i) state_d = REC_OPEN;
            REC_OPEN: begin
                if (set_i)      state_d = REC_OPEN;
                else if (clr_i) state_d = REC_CLOSED;
            end
            default: state_d = REC_CLOSED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= REC_CLOSED;
            row_q   <= '0;
        end else begin
            state_q <= state_d;
            if (set_i) row_q <= row_i;
        end
    end

    always_comb begin
        open_o = (state_q == REC_OPEN);
        row_o  = row_q;
    end
endmodule

// File: rtl/sdram_row_tracker.sv
module sdram_row_tracker
    import row_trk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wide,
    input  logic              cfg_bank_mid,
    input  logic [3:0]        cfg_dens0,
    input  logic [1:0]        cfg_roww0,
    input  logic [1:0]        cfg_colw0,
    input  logic [3:0]        cfg_dens1,
    input  logic [1:0]        cfg_roww1,
    input  logic [1:0]        cfg_colw1,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [1:0]        cls_code,
    output logic              cls_cs,
    output logic [BANK_W-1:0] cls_bank,
    output logic [ROW_W-1:0]  cls_row,
    output logic [COL_W-1:0]  cls_col,
    input  logic              act_valid,
    input  logic              act_cs,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              pre_valid,
    input  logic              pre_cs,
    input  logic [BANK_W-1:0] pre_bank,
    input  logic              pall_valid,
    input  logic              pall_cs
);
    cs_cfg_t cfg0, cfg1;
    logic    dec_err;
    logic [NUM_CS-1:0] four_bank;
    logic [REC_N-1:0]  rec_open;
    logic [ROW_W-1:0]  rec_row [REC_N];
    logic [IDX_W-1:0]  sel_idx;

    always_comb begin
        cfg0 = '{dens: cfg_dens0, roww: cfg_roww0, colw: cfg_colw0};
        cfg1 = '{dens: cfg_dens1, roww: cfg_roww1, colw: cfg_colw1};
        four_bank[0] = (cfg_dens0 >= 4'd2);
        four_bank[1] = (cfg_dens1 >= 4'd2);
    end

    addr_map u_map (
        .cfg_wide     (cfg_wide),
        .cfg_bank_mid (cfg_bank_mid),
        .cfg0         (cfg0),
        .cfg1         (cfg1),
        .addr         (req_addr),
        .err_o        (dec_err),
        .cs_o         (cls_cs),
        .bank_o       (cls_bank),
        .row_o        (cls_row),
        .col_o        (cls_col)
    );

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            logic set_w, clr_w;
            always_comb begin
                set_w = act_valid && (act_cs == 1'(c)) && (act_bank == BANK_W'(b))
                        && (four_bank[c] || (b < 2));
                clr_w = (pall_valid && (pall_cs == 1'(c)))
                        || (pre_valid && (pre_cs == 1'(c)) && (pre_bank == BANK_W'(b)));
            end
            bank_rec u_rec (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (set_w),
                .clr_i  (clr_w),
                .row_i  (act_row),
                .open_o (rec_open[c*BANKS+b]),
                .row_o  (rec_row[c*BANKS+b])
            );
        end
    end

    always_comb begin
        sel_idx = {cls_cs, cls_bank};
        if (!req_valid)
            cls_code = CLS_IDLE;
        else if (dec_err)
            cls_code = CLS_ERR;
        else if (!rec_open[sel_idx])
            cls_code = CLS_IDLE;
        else if (rec_row[sel_idx] == cls_row)
            cls_code = CLS_HIT;
        else
            cls_code = CLS_MISS;
    end
endmodule

// File: rtl/row_trk_chk.sv
module row_trk_chk
    import row_trk_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        cls_code,
    input logic              act_valid,
    input logic              act_cs,
    input logic [BANK_W-1:0] act_bank,
    input logic              pre_valid,
    input logic              pre_cs,
    input logic [BANK_W-1:0] pre_bank,
    input logic              pall_valid,
    input logic              pall_cs,
    input logic [REC_N-1:0]  rec_open
);
    logic             act_q, pre_q, pall_q, pall_cs_q;
    logic [IDX_W-1:0] act_idx_q, pre_idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= 1'b0; pre_q <= 1'b0; pall_q <= 1'b0; pall_cs_q <= 1'b0;
            act_idx_q <= '0; pre_idx_q <= '0;
        end else begin
            act_q     <= act_valid && !act_bank[1];
            act_idx_q <= {act_cs, act_bank};
            pre_q     <= pre_valid && !(act_valid && act_cs == pre_cs && act_bank == pre_bank);
            pre_idx_q <= {pre_cs, pre_bank};
            pall_q    <= pall_valid && !(act_valid && act_cs == pall_cs);
            pall_cs_q <= pall_cs;
        end
    end

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        act_q |-> rec_open[act_idx_q]); // R7
    AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q |-> !rec_open[pre_idx_q]); // R8
    AST_PALL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        pall_q |-> ((pall_cs_q ? rec_open[2*BANKS-1:BANKS] : rec_open[BANKS-1:0]) == '0)); // R9
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> cls_code == CLS_IDLE); // R6
    AST_OUT_OF_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && |req_addr[ADDR_W-1:SPACE_W]) |-> cls_code == CLS_ERR); // R5
endmodule

bind sdram_row_tracker row_trk_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .cls_code   (cls_code),
    .act_valid  (act_valid),
    .act_cs     (act_cs),
    .act_bank   (act_bank),
    .pre_valid  (pre_valid),
    .pre_cs     (pre_cs),
    .pre_bank   (pre_bank),
    .pall_valid (pall_valid),
    .pall_cs    (pall_cs),
    .rec_open   (rec_open)
);

// File: tb/sdram_row_tracker_test.sv
module sdram_row_tracker_test;
    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_wide, cfg_bank_mid;
    logic [3:0] cfg_dens0, cfg_dens1;
    logic [1:0] cfg_roww0, cfg_colw0, cfg_roww1, cfg_colw1;
    logic req_valid;
    logic [31:0] req_addr;
    logic [1:0] cls_code;
    logic cls_cs;
    logic [1:0] cls_bank;
    logic [13:0] cls_row;
    logic [10:0] cls_col;
    logic act_valid, act_cs, pre_valid, pre_cs, pall_valid, pall_cs;
    logic [1:0] act_bank, pre_bank;
    logic [13:0] act_row;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    always #5 clk = ~clk;

    sdram_row_tracker uut (.*);

    function automatic logic [31:0] addr_of(input int cs, input int bank, input int row, input int col);
        int off, cw, rw, bb, cap0;
        logic [31:0] base, loc;
        off  = cfg_wide ? 2 : 1;
        cap0 = off + 8 + int'(cfg_colw0) + 11 + int'(cfg_roww0) + ((cfg_dens0 >= 2) ? 2 : 1);
        cw   = 8 + int'(cs ? cfg_colw1 : cfg_colw0);
        rw   = 11 + int'(cs ? cfg_roww1 : cfg_roww0);
        bb   = ((cs ? cfg_dens1 : cfg_dens0) >= 2) ? 2 : 1;
        base = cs ? (32'd1 << cap0) : 32'd0;
        if (cfg_bank_mid)
            loc = (32'(row) << (off + cw + bb)) | (32'(bank) << (off + cw)) | (32'(col) << off);
        else
            loc = (32'(bank) << (off + cw + rw)) | (32'(row) << (off + cw)) | (32'(col) << off);
        return base + loc;
    endfunction

    task automatic check(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        n_chk++;
        if (actual !== expected) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic [1:0] exp_cls, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        #1 check(tag, 32'(cls_code), 32'(exp_cls));
    endtask

    task automatic probe_fields(input logic [31:0] a, input int cs, input int bank,
                                input int row, input int col, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        #1;
        check({tag, " cs"},   32'(cls_cs),   32'(cs));
        check({tag, " bank"}, 32'(cls_bank), 32'(bank));
        check({tag, " row"},  32'(cls_row),  32'(row));
        check({tag, " col"},  32'(cls_col),  32'(col));
    endtask

    task automatic do_act(input logic cs, input logic [1:0] bank, input logic [13:0] row);
        @(negedge clk);
        act_valid = 1'b1; act_cs = cs; act_bank = bank; act_row = row;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic do_pre(input logic cs, input logic [1:0] bank);
        @(negedge clk);
        pre_valid = 1'b1; pre_cs = cs; pre_bank = bank;
        @(negedge clk);
        pre_valid = 1'b0;
    endtask

    task automatic do_pall(input logic cs);
        @(negedge clk);
        pall_valid = 1'b1; pall_cs = cs;
        @(negedge clk);
        pall_valid = 1'b0;
    endtask

    task automatic t_reset;
        probe(addr_of(0, 0, 0, 0), 2'd0, "R10 cs0 bank0 closed");
        probe(addr_of(1, 1, 3, 0), 2'd0, "R10 cs1 bank1 closed");
        do_act(0, 2'd0, 14'h5);
        @(negedge clk); req_valid = 1'b0;
        #1 check("R6 no request gives idle", 32'(cls_code), 32'd0);
    endtask

    task automatic t_map;
        probe_fields(addr_of(0, 3, 'h1ABC, 'h155), 0, 3, 'h1ABC, 'h155, "R1 cs0 fields");
        probe_fields(addr_of(1, 1, 'hABC, 'h7F), 1, 1, 'hABC, 'h7F, "R5 cs1 fields");
    endtask

    task automatic t_hitmiss;
        do_act(0, 2'd1, 14'h123);
        probe(addr_of(0, 1, 'h123, 5), 2'd1, "R7 hit after activate");
        probe(addr_of(0, 1, 'h124, 0), 2'd2, "R6 miss other row");
        probe(addr_of(0, 2, 'h123, 0), 2'd0, "R6 other bank idle");
        probe(addr_of(1, 1, 'h123, 0), 2'd0, "R11 other cs untouched");
    endtask

    task automatic t_pre;
        do_pre(0, 2'd1);
        probe(addr_of(0, 1, 'h123, 0), 2'd0, "R8 precharge closes");
        @(negedge clk);
        act_valid = 1'b1; act_cs = 0; act_bank = 2'd1; act_row = 14'h77;
        pre_valid = 1'b1; pre_cs = 0; pre_bank = 2'd1;
        @(negedge clk);
        act_valid = 1'b0; pre_valid = 1'b0;
        probe(addr_of(0, 1, 'h77, 0), 2'd1, "R8 activate wins over precharge");
    endtask

    task automatic t_pall;
        do_act(0, 2'd0, 14'h1);
        do_act(0, 2'd3, 14'h2);
        do_act(1, 2'd0, 14'h3);
        do_pall(0);
        probe(addr_of(0, 0, 'h1, 0), 2'd0, "R9 cs0 bank0 cleared");
        probe(addr_of(0, 3, 'h2, 0), 2'd0, "R9 cs0 bank3 cleared");
        probe(addr_of(0, 1, 'h77, 0), 2'd0, "R9 cs0 bank1 cleared");
        probe(addr_of(1, 0, 'h3, 0), 2'd1, "R9 R11 cs1 kept");
    endtask

    task automatic t_ignore;
        do_act(1, 2'd2, 14'h9);
        cfg_dens1 = 4'd4;
        probe(addr_of(1, 2, 'h9, 0), 2'd0, "R7 bank beyond count ignored");
        probe_fields(addr_of(1, 3, 'h11, 'h22), 1, 3, 'h11, 'h22, "R4 four-bank field");
        cfg_dens1 = 4'd1;
    endtask

    task automatic t_order;
        cfg_bank_mid = 1'b1;
        do_act(0, 2'd2, 14'h5);
        probe(addr_of(0, 2, 'h5, 3), 2'd1, "R2 interleaved hit");
        probe_fields(addr_of(0, 2, 'h5, 3), 0, 2, 'h5, 3, "R2 interleaved fields");
        cfg_bank_mid = 1'b0;
        probe_fields(32'((5 << 13) | (2 << 11) | (3 << 2)), 0, 0, 22, 3, "R1 same address linear");
    endtask

    task automatic t_width;
        cfg_wide = 1'b0;
        probe_fields(32'((1 << 23) | ('h10 << 10) | ('h1F3 << 1)), 0, 1, 'h10, 'h1F3, "R3 16-bit offset");
        cfg_wide = 1'b1;
        probe_fields(32'((1 << 24) | ('h10 << 11) | ('h1F3 << 2)), 0, 1, 'h10, 'h1F3, "R3 32-bit offset");
    endtask

    task automatic t_err;
        probe(32'h0480_0000, 2'd3, "R5 just past both cs");
        probe(32'h4000_0000, 2'd3, "R5 above 1GB");
        probe_fields(32'h047F_FFFC, 1, 1, 'hFFF, 'hFF, "R5 last cs1 word");
        probe(32'h047F_FFFC, 2'd0, "R5 last cs1 word valid");
        probe_fields(32'h03FF_FFFC, 0, 3, 'h1FFF, 'h1FF, "R5 last cs0 word");
    endtask

    task automatic t_reset2;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        probe(addr_of(1, 0, 'h3, 0), 2'd0, "R10 reset clears cs1");
        probe(addr_of(0, 2, 'h5, 0), 2'd0, "R10 reset clears cs0");
    endtask

    initial begin
        cfg_wide = 1'b1; cfg_bank_mid = 1'b0;
        cfg_dens0 = 4'd4; cfg_roww0 = 2'd2; cfg_colw0 = 2'd1;
        cfg_dens1 = 4'd1; cfg_roww1 = 2'd1; cfg_colw1 = 2'd0;
        req_valid = 1'b0; req_addr = '0;
        act_valid = 1'b0; act_cs = 1'b0; act_bank = '0; act_row = '0;
        pre_valid = 1'b0; pre_cs = 1'b0; pre_bank = '0;
        pall_valid = 1'b0; pall_cs = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_map;
        t_hitmiss;
        t_pre;
        t_pall;
        t_ignore;
        t_order;
        t_width;
        t_err;
        t_reset2;
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule